// File: doc/BRIEF.md
# Serial Time Frame Transmitter

This block sends the current calendar time over one asynchronous serial line as a fixed ten-byte packet. A send request, usually a once-per-second tick, causes the block to copy six binary time fields into its own buffer in the same clock edge. Those fields are second, minute, hour, day, month and two-digit year. The block then shifts the packet out through a built-in 8N1 transmitter while a busy flag is high.

The packet contains two synchronisation bytes, the six payload bytes, an XOR check byte over the payload and a terminating byte. A receiver can use the synchronisation pair to find the start of a packet again after it loses its place. Inside the block, a control module counts bit periods, symbols and bytes. It drives a small strobe struct that tells the datapath when to capture, load and shift. The datapath holds the snapshot, the check byte and the shift register.

Top module: `time_frame_tx`

## Requirements
- R1: A packet is exactly 10 bytes. Byte 0 is 0xA5 and byte 1 is 0x5A.
- R2: Bytes 2 to 7 carry second, minute, hour, day, month and year in that order. Each is the 7-bit binary input with a zero in bit 7.
- R3: Byte 8 equals the XOR of bytes 2 through 7.
- R4: Byte 9 is the terminator 0x0D.
- R5: Every byte goes out as ten symbols: a low start bit, eight data bits least-significant first, and a high stop bit. Each symbol lasts CLK_HZ/BAUD clock cycles.
- R6: The first start bit begins in the cycle after the accepting edge. Each following start bit comes directly after the previous stop bit, with no idle time between bytes.
- R7: All six fields are sampled on the accepting edge. Input changes after that edge do not alter the packet in flight.
- R8: `busy` is high from the cycle after acceptance to the end of the last stop bit. A `sendReq` that arrives while `busy` is high is ignored and starts no packet.
- R9: While reset is low, and whenever no packet is in flight, `txOut` is high and `busy` is low. Reset is asynchronous and ends a packet immediately.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| secIn | input | 7 | Seconds, binary |
| minIn | input | 7 | Minutes, binary |
| hourIn | input | 7 | Hours, binary |
| dayIn | input | 7 | Day of month, binary |
| monIn | input | 7 | Month, binary |
| yearIn | input | 7 | Two-digit year, binary |
| sendReq | input | 1 | Send request, accepted when not busy |
| txOut | output | 1 | Serial line, idles high |
| busy | output | 1 | High while a packet is in flight |

## Verification
The bench builds the block with CLK_HZ=16 and BAUD=4, so each symbol lasts four cycles and a whole packet lasts 400 cycles. At that size the bench can sample every symbol of many packets at its midpoint. This covers payload edge values, input changes in the middle of a packet, a request during busy, a reset in the middle of a packet, and the idle gap after a packet. The bench stays far inside its cycle limit. The default 434-cycle period exercises the same counter logic, only with a wider count.

// File: rtl/time_frame_pkg.sv
package time_frame_pkg;
  localparam int FRAME_BYTES   = 10;
  localparam int SYMS_PER_BYTE = 10;
  localparam int FIELD_COUNT   = 6;
  localparam int FIELD_W       = 7;

  localparam logic [7:0] SYNC_HI  = 8'hA5;
  localparam logic [7:0] SYNC_LO  = 8'h5A;
  localparam logic [7:0] TERM_VAL = 8'h0D;

  typedef logic [3:0] byte_idx_t;

  typedef struct packed {
    logic      capture;
    logic      loadByte;
    logic      shiftBit;
    byte_idx_t byteSel;
  } frame_strobe_t;
endpackage

// File: rtl/time_frame_ctrl.sv
module time_frame_ctrl
  import time_frame_pkg::*;
#(
  parameter int CLKS_PER_BIT = 434
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          sendReq,
  output frame_strobe_t strb,
  output logic          busy
);
  localparam int CNT_W = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST  = CNT_W'(CLKS_PER_BIT - 1);
  localparam byte_idx_t        SYM_LAST  = byte_idx_t'(SYMS_PER_BYTE - 1);
  localparam byte_idx_t        BYTE_LAST = byte_idx_t'(FRAME_BYTES - 1);

  logic [CNT_W-1:0] baudCnt;
  byte_idx_t        symCnt;
  byte_idx_t        byteCnt;
  logic             accept;
  logic             symEnd;
  logic             lastSym;
  logic             lastByte;

  always_comb begin
    accept        = sendReq && !busy;
    symEnd        = busy && (baudCnt == CNT_LAST);
    lastSym       = (symCnt == SYM_LAST);
    lastByte      = (byteCnt == BYTE_LAST);
    strb.capture  = accept;
    strb.loadByte = accept || (symEnd && lastSym && !lastByte);
    strb.shiftBit = symEnd && !lastSym;
    strb.byteSel  = accept ? '0 : byteCnt + byte_idx_t'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      baudCnt <= '0;
      symCnt  <= '0;
      byteCnt <= '0;
    end else if (accept) begin
      busy    <= 1'b1;
      baudCnt <= '0;
      symCnt  <= '0;
      byteCnt <= '0;
    end else if (busy) begin
      if (symEnd) begin
        baudCnt <= '0;
        if (lastSym) begin
          symCnt <= '0;
          if (lastByte) busy <= 1'b0;
          else          byteCnt <= byteCnt + byte_idx_t'(1);
        end else begin
          symCnt <= symCnt + byte_idx_t'(1);
        end
      end else begin
        baudCnt <= baudCnt + CNT_W'(1);
      end
    end
  end

  // R8: an accepted request raises busy on the next cycle
  a_r8_accept_busy: assert property (@(posedge clk) disable iff (!rstN)
    (sendReq && !busy) |=> busy);
  // R8: a request during busy never triggers a capture
  a_r8_ignore_busy: assert property (@(posedge clk) disable iff (!rstN)
    (sendReq && busy) |-> !strb.capture);
  // R6: loading a new byte and shifting never coincide
  a_r6_load_xor_shift: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadByte |-> !strb.shiftBit);
endmodule

// File: rtl/time_frame_dp.sv
module time_frame_dp
  import time_frame_pkg::*;
(
  input  logic                                clk,
  input  logic                                rstN,
  input  frame_strobe_t                       strb,
  input  logic                                busy,
  input  logic [FIELD_COUNT-1:0][FIELD_W-1:0] fieldIn,
  output logic                                txOut
);
  localparam int SHIFT_W = SYMS_PER_BYTE;

  logic [FIELD_COUNT-1:0][7:0] snap;
  logic [7:0]                  csum;
  logic [SHIFT_W-1:0]          shreg;
  logic [7:0]                  nextByte;
  logic                        isPayload;

  always_comb begin
    isPayload = (strb.byteSel >= byte_idx_t'(2)) && (strb.byteSel <= byte_idx_t'(7));
    case (strb.byteSel)
      4'd0:    nextByte = SYNC_HI;
      4'd1:    nextByte = SYNC_LO;
      4'd2:    nextByte = snap[0];
      4'd3:    nextByte = snap[1];
      4'd4:    nextByte = snap[2];
      4'd5:    nextByte = snap[3];
      4'd6:    nextByte = snap[4];
      4'd7:    nextByte = snap[5];
      4'd8:    nextByte = csum;
      4'd9:    nextByte = TERM_VAL;
      default: nextByte = 8'hFF;
    endcase
  end

  for (genvar f = 0; f < FIELD_COUNT; f++) begin : g_snap
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            snap[f] <= '0;
      else if (strb.capture) snap[f] <= {1'b0, fieldIn[f]};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csum  <= '0;
      shreg <= '1;
    end else begin
      if (strb.capture) csum <= '0;
      if (strb.loadByte) begin
        shreg <= {1'b1, nextByte, 1'b0};
        if (isPayload) csum <= csum ^ nextByte;
      end else if (strb.shiftBit) begin
        shreg <= {1'b1, shreg[SHIFT_W-1:1]};
      end
    end
  end

  assign txOut = shreg[0];

  // R9: line is high whenever no packet is in flight
  a_r9_idle_high: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> txOut);
  // R5: each loaded byte starts with a low start bit
  a_r5_start_low: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadByte |=> !txOut);
  // R3: check byte equals XOR of the captured payload
  a_r3_checksum: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadByte && strb.byteSel == 4'd8) |=>
      shreg[8:1] == (snap[0] ^ snap[1] ^ snap[2] ^ snap[3] ^ snap[4] ^ snap[5]));
  // R4: terminator loaded as last byte
  a_r4_term: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadByte && strb.byteSel == 4'd9) |=> shreg[8:1] == TERM_VAL);
  // R7: snapshot held for the whole packet
  a_r7_snap_held: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !strb.capture) |=> $stable(snap));
endmodule

// File: rtl/time_frame_tx.sv
module time_frame_tx
  import time_frame_pkg::*;
#(
  parameter int CLK_HZ = 50_000_000,
  parameter int BAUD   = 115_200
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [6:0] secIn,
  input  logic [6:0] minIn,
  input  logic [6:0] hourIn,
  input  logic [6:0] dayIn,
  input  logic [6:0] monIn,
  input  logic [6:0] yearIn,
  input  logic       sendReq,
  output logic       txOut,
  output logic       busy
);
  localparam int CLKS_PER_BIT = CLK_HZ / BAUD;

  frame_strobe_t                       strb;
  logic [FIELD_COUNT-1:0][FIELD_W-1:0] fieldBus;

  assign fieldBus = {yearIn, monIn, dayIn, hourIn, minIn, secIn};

  time_frame_ctrl #(.CLKS_PER_BIT(CLKS_PER_BIT)) ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .sendReq(sendReq),
    .strb   (strb),
    .busy   (busy)
  );

  time_frame_dp dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .busy   (busy),
    .fieldIn(fieldBus),
    .txOut  (txOut)
  );
endmodule

// File: tb/time_frame_tx_tb.sv
module time_frame_tx_tb_top;
  localparam int CLK_HZ = 16;
  localparam int BAUD   = 4;
  localparam int CPB    = CLK_HZ / BAUD;
  localparam int FRAME_CYC = 100 * CPB;
  localparam int NVEC = 5;

  // packed {year, month, day, hour, minute, second}
  localparam logic [41:0] VEC [NVEC] = '{
    {7'd0,   7'd1,  7'd1,   7'd0,  7'd0,   7'd0},
    {7'd99,  7'd12, 7'd31,  7'd23, 7'd59,  7'd59},
    {7'd25,  7'd7,  7'd6,   7'd5,  7'd34,  7'd12},
    {7'd0,   7'd127,7'd0,   7'd127,7'd0,   7'd127},
    {7'd85,  7'd42, 7'd85,  7'd42, 7'd85,  7'd42}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [6:0] secIn = '0, minIn = '0, hourIn = '0, dayIn = '0, monIn = '0, yearIn = '0;
  logic sendReq = 1'b0;
  logic txOut, busy;

  int nChecks = 0;
  int nFails  = 0;
  logic [7:0] rxB [10];
  int badFrame;
  int busyLow;

  always #4 clk = ~clk;

  time_frame_tx #(.CLK_HZ(CLK_HZ), .BAUD(BAUD)) dut_i (
    .clk(clk), .rstN(rstN),
    .secIn(secIn), .minIn(minIn), .hourIn(hourIn),
    .dayIn(dayIn), .monIn(monIn), .yearIn(yearIn),
    .sendReq(sendReq), .txOut(txOut), .busy(busy)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic setFields(input logic [41:0] v);
    {yearIn, monIn, dayIn, hourIn, minIn, secIn} = v;
  endtask

  function automatic logic [7:0] expByte(input logic [41:0] v, input int i);
    logic [7:0] p [6];
    logic [7:0] x;
    for (int j = 0; j < 6; j++) p[j] = {1'b0, v[j*7 +: 7]};
    x = p[0] ^ p[1] ^ p[2] ^ p[3] ^ p[4] ^ p[5];
    case (i)
      0: return 8'hA5;
      1: return 8'h5A;
      8: return x;
      9: return 8'h0D;
      default: return p[i-2];
    endcase
  endfunction

  // starts a packet and samples every symbol at mid-period
  task automatic runFrame();
    badFrame = 0;
    busyLow  = 0;
    @(negedge clk) sendReq = 1'b1;
    @(posedge clk);
    for (int k = 0; k < FRAME_CYC; k++) begin
      @(negedge clk);
      if (k == 0) sendReq = 1'b0;
      if (!busy) busyLow++;
      if (k % CPB == CPB / 2) begin
        int g, by, sy;
        g  = k / CPB;
        by = g / 10;
        sy = g % 10;
        if (sy == 0)      begin if (txOut !== 1'b0) badFrame++; end
        else if (sy == 9) begin if (txOut !== 1'b1) badFrame++; end
        else rxB[by][sy-1] = txOut;
      end
    end
    @(negedge clk);
  endtask

  task automatic checkFrame(input logic [41:0] v, input string tag);
    for (int i = 0; i < 10; i++) begin
      string req;
      req = (i < 2) ? "R1 sync" : (i == 8) ? "R3 checksum" : (i == 9) ? "R4 terminator" : "R2 payload";
      chk($sformatf("%s byte %0d %s", req, i, tag), rxB[i], expByte(v, i));
    end
    chk({"R5 R6 framing ", tag}, badFrame, 0);
    chk({"R8 busy during packet ", tag}, busyLow, 0);
    chk({"R8 busy low after packet ", tag}, busy, 1'b0);
    chk({"R9 idle high after packet ", tag}, txOut, 1'b1);
  endtask

  initial begin
    #(200000 * 8);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 txOut in reset", txOut, 1'b1);
    chk("R9 busy in reset", busy, 1'b0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 txOut after reset", txOut, 1'b1);
    chk("R9 busy after reset", busy, 1'b0);

    for (int n = 0; n < NVEC; n++) begin
      setFields(VEC[n]);
      runFrame();
      checkFrame(VEC[n], $sformatf("vec%0d", n));
    end

    // R7: inputs changed mid-packet
    setFields(VEC[2]);
    fork
      runFrame();
      begin
        repeat (8) @(negedge clk);
        setFields(VEC[1]);
      end
    join
    checkFrame(VEC[2], "R7 inputs changed");

    // R8: request while busy is ignored
    setFields(VEC[4]);
    fork
      runFrame();
      begin
        repeat (51) @(negedge clk);
        sendReq = 1'b1;
        @(negedge clk);
        sendReq = 1'b0;
      end
    join
    checkFrame(VEC[4], "R8 mid request");
    begin
      int stray;
      stray = 0;
      for (int k = 0; k < 30 * CPB; k++) begin
        @(negedge clk);
        if (busy || !txOut) stray++;
      end
      chk("R8 ignored request started no packet", stray, 0);
    end

    // R9: reset in the middle of a packet
    @(negedge clk) sendReq = 1'b1;
    @(negedge clk) sendReq = 1'b0;
    repeat (30) @(negedge clk);
    chk("R8 busy before mid reset", busy, 1'b1);
    rstN = 1'b0;
    #1;
    chk("R9 txOut at mid reset", txOut, 1'b1);
    chk("R9 busy at mid reset", busy, 1'b0);
    @(negedge clk) rstN = 1'b1;
    repeat (2) @(negedge clk);

    // recovery after reset
    setFields(VEC[0]);
    runFrame();
    checkFrame(VEC[0], "R9 after mid reset");

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule